// File: doc/BRIEF.md
# Inter-Core Interrupt Unit

This unit sits between the cores of a small multicore cluster and carries interrupts from one core to another. Every core owns a command port, made of a valid strobe, an 8-bit opcode and a 16-bit parameter, plus a readback register and one interrupt line. A core that wants to signal a peer issues a raise command that names the peer. Before raising, a sender can ask whether the peer already has an interrupt waiting.

The unit keeps one pending bit for each ordered pair of receiver and sender. When a receiver is interrupted, it asks which cores signalled it and gets back a bitmask with one bit per sender. It then clears those senders one at a time. Repeated raises to the same receiver collapse into the single pending bit, so no extra interrupt edge is produced. Commands from different cores all take effect in the same clock cycle.

Top module: `xcore_irq_unit`

## Requirements
- R1: After reset every pending bit is clear, every interrupt line is low and every readback register reads zero.
- R2: A raise command (opcode 0x01) from core s, with a parameter t below the core count and t not equal to s, sets the pending bit (receiver t, sender s). The interrupt line of core t is high in the cycle after the command edge.
- R3: A raise that names the issuing core itself, or a parameter at or above the core count, changes no pending bit and no interrupt line.
- R4: Any number of raises from one sender to one receiver occupy a single pending bit, and one clear command removes it.
- R5: A status query (opcode 0x02) naming core t loads the issuer's readback with bit 0 set when any interrupt to t is pending; all other bits read zero. The answer reflects the state just before the command edge.
- R6: A source query (opcode 0x03) loads the issuer's readback with its pending row: bit s is set when sender s has an interrupt waiting for the issuer. Several bits may be set at once.
- R7: A clear command (opcode 0x04) from receiver r naming sender s clears only bit (r, s). The interrupt line of r stays high while any other sender bit of r remains set.
- R8: When a raise and a clear hit the same (receiver, sender) bit in the same cycle, the bit ends up set.
- R9: Commands presented by several cores in the same cycle all take effect at that edge.
- R10: An unknown opcode, or any command whose valid strobe is low, changes nothing. A readback register changes only on a status or source query from its own core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | NUM_CORES | One command strobe per core |
| cmdOp | input | NUM_CORES*8 | Opcode per core, core c at bits [c*8 +: 8] |
| cmdParam | input | NUM_CORES*16 | Parameter (core index) per core, core c at bits [c*16 +: 16] |
| readback | output | NUM_CORES*NUM_CORES | Query result per core, core c at bits [c*N +: N] |
| irqOut | output | NUM_CORES | Interrupt line per core |

## Verification
Each command is registered at the first rising edge where it is presented. Both the pending matrix, and with it every interrupt line, and the readback registers take their new values at that same edge. Query results therefore describe the state before that edge. The driver presents each command set at a falling edge and records the expected lines and readbacks once the next rising edge has passed. The monitor compares them at the following falling edge, one cycle after the stimulus, when every result is due and stable.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int OP_W    = 8;
  localparam int PARAM_W = 16;

  localparam logic [OP_W-1:0] OP_RAISE  = 8'h01;
  localparam logic [OP_W-1:0] OP_STATUS = 8'h02;
  localparam logic [OP_W-1:0] OP_SOURCE = 8'h03;
  localparam logic [OP_W-1:0] OP_CLEAR  = 8'h04;

  // one decoded action per core and cycle
  typedef struct packed {
    logic raise;
    logic status;
    logic source;
    logic clear;
  } cmdStrb_t;
endpackage

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_CORES-1:0]                cmdValid,
  input  logic [NUM_CORES*OP_W-1:0]           cmdOp,
  input  logic [NUM_CORES*PARAM_W-1:0]        cmdParam,
  output cmdStrb_t                            strb [NUM_CORES],
  output logic [NUM_CORES-1:0][IDX_W-1:0]     tgtIdx
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_dec
    logic [OP_W-1:0]    opC;
    logic [PARAM_W-1:0] prmC;
    logic               inRange;
    logic               isSelf;

    assign opC     = cmdOp[c*OP_W +: OP_W];
    assign prmC    = cmdParam[c*PARAM_W +: PARAM_W];
    assign inRange = (prmC < PARAM_W'(NUM_CORES));
    assign isSelf  = (prmC == PARAM_W'(c));
    assign tgtIdx[c] = prmC[IDX_W-1:0];

    always_comb begin
      strb[c] = '0;
      if (cmdValid[c] && inRange) begin
        unique case (opC)
          OP_RAISE:  strb[c].raise  = !isSelf;
          OP_STATUS: strb[c].status = 1'b1;
          OP_SOURCE: strb[c].source = 1'b1;
          OP_CLEAR:  strb[c].clear  = 1'b1;
          default:   strb[c] = '0;
        endcase
      end
    end

    // R10: at most one action per core and cycle
    a_r10_one_action: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({strb[c].raise, strb[c].status, strb[c].source, strb[c].clear}));
    // R3: a raise never targets its own core
    a_r3_no_self_raise: assert property (@(posedge clk) disable iff (!rst_n)
      strb[c].raise |-> (tgtIdx[c] != IDX_W'(c)));
  end
endmodule

// File: rtl/xirq_datapath.sv
module xirq_datapath
  import xirq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  cmdStrb_t                            strb [NUM_CORES],
  input  logic [NUM_CORES-1:0][IDX_W-1:0]     tgtIdx,
  output logic [NUM_CORES*NUM_CORES-1:0]      readback,
  output logic [NUM_CORES-1:0]                irqOut
);
  // pendQ[receiver][sender]
  logic [NUM_CORES-1:0][NUM_CORES-1:0] pendQ, pendD;
  logic [NUM_CORES-1:0][NUM_CORES-1:0] setHit, clrHit;
  logic [NUM_CORES-1:0][NUM_CORES-1:0] rbQ;

  always_comb begin
    for (int r = 0; r < NUM_CORES; r++) begin
      for (int s = 0; s < NUM_CORES; s++) begin
        setHit[r][s] = strb[s].raise && (tgtIdx[s] == IDX_W'(r));
        clrHit[r][s] = strb[r].clear && (tgtIdx[r] == IDX_W'(s));
        // set has priority over clear
        pendD[r][s]  = setHit[r][s] | (pendQ[r][s] & ~clrHit[r][s]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pendQ <= '0;
    else        pendQ <= pendD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbQ <= '0;
    end else begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (strb[c].status)      rbQ[c] <= NUM_CORES'(|pendQ[tgtIdx[c]]);
        else if (strb[c].source) rbQ[c] <= pendQ[c];
      end
    end
  end

  for (genvar r = 0; r < NUM_CORES; r++) begin : g_out
    assign irqOut[r] = |pendQ[r];
    assign readback[r*NUM_CORES +: NUM_CORES] = rbQ[r];

    // R3: no core ever holds an interrupt from itself
    a_r3_diag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !pendQ[r][r]);

    for (genvar s = 0; s < NUM_CORES; s++) begin : g_bit
      // R2: a pending bit only appears after a raise from that sender
      a_r2_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pendQ[r][s]) |-> $past(strb[s].raise && tgtIdx[s] == IDX_W'(r)));
      // R7: a pending bit only disappears after a clear by that receiver
      a_r7_clr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pendQ[r][s]) |-> $past(strb[r].clear && tgtIdx[r] == IDX_W'(s)));
      // R8: raise wins over a clear of the same bit
      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (strb[s].raise && tgtIdx[s] == IDX_W'(r) &&
         strb[r].clear && tgtIdx[r] == IDX_W'(s)) |=> pendQ[r][s]);
    end

    // R10: readback changes only after a query from its own core
    a_r10_rb_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb[r].status && !strb[r].source) |=> $stable(rbQ[r]));
  end
endmodule

// File: rtl/xcore_irq_unit.sv
module xcore_irq_unit
  import xirq_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CORES-1:0]           cmdValid,
  input  logic [NUM_CORES*8-1:0]         cmdOp,
  input  logic [NUM_CORES*16-1:0]        cmdParam,
  output logic [NUM_CORES*NUM_CORES-1:0] readback,
  output logic [NUM_CORES-1:0]           irqOut
);
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  cmdStrb_t                        strb [NUM_CORES];
  logic [NUM_CORES-1:0][IDX_W-1:0] tgtIdx;

  xirq_ctrl #(.NUM_CORES(NUM_CORES)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdParam (cmdParam),
    .strb     (strb),
    .tgtIdx   (tgtIdx)
  );

  xirq_datapath #(.NUM_CORES(NUM_CORES)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .tgtIdx   (tgtIdx),
    .readback (readback),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/xcore_irq_unit_tb.sv
module xcore_irq_unit_tb_top;
  localparam int N = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     cmdValid = '0;
  logic [N*8-1:0]   cmdOp = '0;
  logic [N*16-1:0]  cmdParam = '0;
  logic [N*N-1:0]   readback;
  logic [N-1:0]     irqOut;

  always #5 clk = ~clk;

  xcore_irq_unit #(.NUM_CORES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdParam(cmdParam), .readback(readback), .irqOut(irqOut)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // reference state: mPend[receiver][sender]
  logic [N-1:0] mPend [N];
  logic [N-1:0] mRb [N];

  // pending stimulus for the next cycle
  logic [7:0]  stOp [N];
  logic [15:0] stPrm [N];

  // scoreboard queues
  logic [N-1:0]   qIrq [$];
  logic [N*N-1:0] qRb [$];
  string          qTag [$];

  task automatic clearStim();
    for (int c = 0; c < N; c++) begin stOp[c] = 8'h00; stPrm[c] = 16'h0; end
  endtask

  task automatic setCmd(input int core, input logic [7:0] op, input logic [15:0] prm);
    stOp[core] = op; stPrm[core] = prm;
  endtask

  task automatic doCycle(input string tag);
    logic [N-1:0] nextPend [N];
    logic [N-1:0] expIrq;
    logic [N*N-1:0] expRb;
    @(negedge clk);
    for (int c = 0; c < N; c++) begin
      cmdValid[c] = (stOp[c] != 8'h00);
      cmdOp[c*8 +: 8] = stOp[c];
      cmdParam[c*16 +: 16] = stPrm[c];
    end
    // queries see the state before the edge
    for (int c = 0; c < N; c++) begin
      if (stOp[c] == 8'h02 && stPrm[c] < N) mRb[c] = {3'b000, |mPend[stPrm[c]]};
      else if (stOp[c] == 8'h03 && stPrm[c] < N) mRb[c] = mPend[c];
    end
    for (int r = 0; r < N; r++) nextPend[r] = mPend[r];
    for (int c = 0; c < N; c++)
      if (stOp[c] == 8'h04 && stPrm[c] < N) nextPend[c][stPrm[c]] = 1'b0;
    for (int c = 0; c < N; c++)
      if (stOp[c] == 8'h01 && stPrm[c] < N && stPrm[c] != c) nextPend[stPrm[c]][c] = 1'b1;
    for (int r = 0; r < N; r++) mPend[r] = nextPend[r];
    for (int r = 0; r < N; r++) begin
      expIrq[r] = |mPend[r];
      expRb[r*N +: N] = mRb[r];
    end
    @(posedge clk);
    qIrq.push_back(expIrq);
    qRb.push_back(expRb);
    qTag.push_back(tag);
    clearStim();
  endtask

  // monitor: compares one cycle after each stimulus
  always @(negedge clk) begin
    while (qTag.size() > 0) begin
      logic [N-1:0] eI;
      logic [N*N-1:0] eR;
      string t;
      eI = qIrq.pop_front();
      eR = qRb.pop_front();
      t  = qTag.pop_front();
      testsRun++;
      if (irqOut !== eI || readback !== eR) begin
        testsFailed++;
        $display("FAIL %s: irq=%b rb=%h expected irq=%b rb=%h", t, irqOut, readback, eI, eR);
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < N; r++) begin mPend[r] = '0; mRb[r] = '0; end
    clearStim();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    doCycle("R1 reset state");
    setCmd(0, 8'h01, 16'd2);                       doCycle("R2 raise 0->2");
    setCmd(1, 8'h02, 16'd2); setCmd(3, 8'h02, 16'd1); doCycle("R5 status query");
    setCmd(2, 8'h03, 16'd0);                       doCycle("R6 source single");
    setCmd(0, 8'h01, 16'd2); setCmd(1, 8'h01, 16'd2); setCmd(3, 8'h01, 16'd2);
    doCycle("R9 concurrent raises, R4 coalesce");
    setCmd(2, 8'h03, 16'd0);                       doCycle("R6 source multi");
    setCmd(2, 8'h04, 16'd0);                       doCycle("R4 one clear after two raises");
    setCmd(2, 8'h03, 16'd0);                       doCycle("R7 clear only named sender");
    setCmd(1, 8'h01, 16'd1); setCmd(0, 8'h01, 16'd9); doCycle("R3 self and range raise");
    setCmd(1, 8'h03, 16'd0); setCmd(0, 8'h03, 16'd0); doCycle("R3 no bit from ignored raise");
    setCmd(2, 8'h7F, 16'd1); setCmd(3, 8'h04, 16'd1); doCycle("R10 unknown op and idle clear");
    setCmd(1, 8'h01, 16'd2); setCmd(2, 8'h04, 16'd1); doCycle("R8 raise vs clear same bit");
    setCmd(2, 8'h03, 16'd0);                       doCycle("R8 bit survives");
    setCmd(2, 8'h04, 16'd1); setCmd(0, 8'h01, 16'd3); doCycle("R7 clear with other pending");
    setCmd(2, 8'h04, 16'd3); setCmd(3, 8'h04, 16'd0); doCycle("R7 last clears, R9 parallel");
    setCmd(3, 8'h02, 16'd2); setCmd(1, 8'h03, 16'd0); doCycle("R5 status idle target");
    doCycle("R10 readback holds");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule